// File: doc/BRIEF.md
# Configuration Scrub Controller

This controller keeps a frame-organised configuration store consistent with a golden image. On a programmable cycle period it walks every frame word by word, reads each word from the store and compares it against the golden word at the same address. A frame with any differing word is rewritten from the golden image, frame only, and then read back once to confirm the fix. The rest of the store is left untouched, and the user logic stays enabled while this happens.

When the functional-interrupt input reports an event, the controller drops the pass it is running. It then rewrites the whole store from address zero upward and holds the user-logic enable low until the final word is accepted. Only configuration frames are addressed. Memory blocks that user logic shares through an output register are outside the address range and are never read back.

The store port is a request channel with valid/ready. A request (read or write, address, write data) is presented with valid high and is held unchanged until ready is high at a clock edge. There is no back-pressure on read responses: they arrive with a response valid pulse and are always taken, and only one read is ever outstanding. The golden port is a combinational lookup, so the golden word is expected in the same cycle as its address.

Top module: `scrub_ctrl`

## Requirements
- R1: Successive scrub passes start exactly `scrub_period_i` cycles apart, measured between rising edges of `busy_o`, whenever a pass finishes inside that window. The first pass starts `scrub_period_i` cycles after reset.
- R2: A pass with no mismatch reads every word at addresses 0 to FRAMES*WORDS-1 exactly once, where address = frame*WORDS + word, and it issues no write.
- R3: A frame with at least one word differing from the golden word is rewritten: exactly its WORDS words, with golden data, followed by one confirming read of those words. `repaired_o` rises by one for each rewritten frame, so a clean pass plus k repaired frames gives 12+4k reads and 4k writes for a 3x4 store.
- R4: `user_en_o` stays high through scrub passes and frame repairs.
- R5: `repair_fail_o` is set when the confirming read of a rewritten frame still mismatches. Only reset clears it.
- R6: A rising edge of `sefi_i` drives `user_en_o` low from the next cycle. The running pass is abandoned without counting a repair, and every word is written with golden data in ascending address order from 0. `user_en_o` returns high, and `busy_o` low, once the last write is accepted.
- R7: A request held with valid high and ready low keeps its valid, address and write flag unchanged in the next cycle.
- R8: No request addresses a location at or above FRAMES*WORDS.
- R9: After reset `busy_o`, `repair_fail_o` and `mem_req_valid_o` are 0, `user_en_o` is 1 and `repaired_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| scrub_period_i | input | PERIOD_W | Cycles between pass starts |
| sefi_i | input | 1 | Functional-interrupt report, rising edge acts |
| mem_req_valid_o | output | 1 | Store request valid |
| mem_req_ready_i | input | 1 | Store accepts the request |
| mem_req_we_o | output | 1 | 1 write, 0 read |
| mem_req_addr_o | output | ADDR_W | Word address, frame*WORDS+word |
| mem_req_wdata_o | output | DATA_W | Write data (golden word) |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | DATA_W | Read data |
| gold_addr_o | output | ADDR_W | Golden lookup address |
| gold_data_i | input | DATA_W | Golden word for gold_addr_o |
| busy_o | output | 1 | Pass or reconfiguration in progress |
| user_en_o | output | 1 | User logic may run |
| repaired_o | output | CNT_W | Frames rewritten, saturating |
| repair_fail_o | output | 1 | Sticky: frame still wrong after rewrite |

## Verification
Several properties are checked on every cycle: a stalled request stays stable, the frame cursor stays inside the store, a functional-interrupt edge disables user logic in the following cycle, a full rewrite opens at address zero, the repair count moves by single steps, the failure flag is sticky, and a pass only starts when the period is due. Other properties can only be shown through the bench scenarios. These are the exact spacing of passes, the read and write totals for a given set of injected upsets, the store matching the golden image after repair, a dropped write raising the failure flag, and the complete ascending rewrite after an abandoned pass.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_RWAIT,
    ST_FIX,
    ST_FULL
  } scrub_st_e;
endpackage

// File: rtl/scrub_period_timer.sv
module scrub_period_timer #(
  parameter int PERIOD_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                restart_i,
  output logic                due_o
);
  logic [PERIOD_W-1:0] elapsed_q;

  // Cycles since the last pass start, saturating.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
    end else if (restart_i) begin
      elapsed_q <= PERIOD_W'(1);
    end else if (elapsed_q != '1) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  assign due_o = (elapsed_q >= period_i);

  AST_START_WHEN_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> due_o); // R1
endmodule

// File: rtl/scrub_cursor.sv
module scrub_cursor #(
  parameter int FRAMES = 8,
  parameter int WORDS  = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wrap_i,
  input  logic              step_word_i,
  input  logic              step_frame_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_word_o,
  output logic              last_frame_o
);
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int WORD_W  = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [FRAME_W-1:0] frame_q;
  logic [WORD_W-1:0]  word_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      frame_q <= '0;
      word_q  <= '0;
    end else if (clear_i) begin
      frame_q <= '0;
      word_q  <= '0;
    end else if (step_frame_i) begin
      frame_q <= frame_q + 1'b1;
      word_q  <= '0;
    end else if (wrap_i) begin
      word_q  <= '0;
    end else if (step_word_i) begin
      word_q  <= word_q + 1'b1;
    end
  end

  assign last_word_o  = (word_q == WORD_W'(WORDS - 1));
  assign last_frame_o = (frame_q == FRAME_W'(FRAMES - 1));
  assign addr_o       = ADDR_W'(frame_q) * ADDR_W'(WORDS) + ADDR_W'(word_q);

  AST_CURSOR_IN_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(word_q) < WORDS) && (int'(frame_q) < FRAMES)); // R8
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int FRAMES   = 8,
  parameter int WORDS    = 16,
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 24,
  parameter int CNT_W    = 16,
  localparam int TOTAL   = FRAMES * WORDS,
  localparam int ADDR_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] scrub_period_i,
  input  logic                sefi_i,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic                mem_req_we_o,
  output logic [ADDR_W-1:0]   mem_req_addr_o,
  output logic [DATA_W-1:0]   mem_req_wdata_o,
  input  logic                mem_rsp_valid_i,
  input  logic [DATA_W-1:0]   mem_rsp_data_i,
  output logic [ADDR_W-1:0]   gold_addr_o,
  input  logic [DATA_W-1:0]   gold_data_i,
  output logic                busy_o,
  output logic                user_en_o,
  output logic [CNT_W-1:0]    repaired_o,
  output logic                repair_fail_o
);
  scrub_st_e         state_q, state_d;
  logic              verify_q, verify_d;
  logic              mism_q, mism_d, mism_now;
  logic              sefi_q, sefi_rise, pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              fail_q;
  logic              due, pass_start, go_full, stalled, hs;
  logic              cur_clear, cur_wrap, cur_word, cur_frame;
  logic              last_word, last_frame;
  logic              fix_done, fail_hit;
  logic [ADDR_W-1:0] cur_addr;

  scrub_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .period_i  (scrub_period_i),
    .restart_i (pass_start),
    .due_o     (due)
  );

  scrub_cursor #(.FRAMES(FRAMES), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_cursor (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (cur_clear),
    .wrap_i       (cur_wrap),
    .step_word_i  (cur_word),
    .step_frame_i (cur_frame),
    .addr_o       (cur_addr),
    .last_word_o  (last_word),
    .last_frame_o (last_frame)
  );

  // Request channel: valid held until ready; writes always carry golden data.
  assign mem_req_valid_o = (state_q == ST_READ) || (state_q == ST_FIX) || (state_q == ST_FULL);
  assign mem_req_we_o    = (state_q == ST_FIX) || (state_q == ST_FULL);
  assign mem_req_addr_o  = cur_addr;
  assign gold_addr_o     = cur_addr;
  assign mem_req_wdata_o = gold_data_i;

  assign hs        = mem_req_valid_o && mem_req_ready_i;
  assign stalled   = mem_req_valid_o && !mem_req_ready_i;
  assign sefi_rise = sefi_i && !sefi_q;
  // An interrupt takes over only where no request is waiting for acceptance.
  assign go_full   = pend_q && !stalled;
  assign mism_now  = mism_q || (mem_rsp_data_i != gold_data_i);

  always_comb begin
    state_d    = state_q;
    verify_d   = verify_q;
    mism_d     = mism_q;
    cur_clear  = 1'b0;
    cur_wrap   = 1'b0;
    cur_word   = 1'b0;
    cur_frame  = 1'b0;
    fix_done   = 1'b0;
    fail_hit   = 1'b0;
    pass_start = 1'b0;
    if (go_full) begin
      state_d   = ST_FULL;
      cur_clear = 1'b1;
      verify_d  = 1'b0;
      mism_d    = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (due) begin
            pass_start = 1'b1;
            state_d    = ST_READ;
            cur_clear  = 1'b1;
            verify_d   = 1'b0;
            mism_d     = 1'b0;
          end
        end
        ST_READ: begin
          if (hs) state_d = ST_RWAIT;
        end
        ST_RWAIT: begin
          if (mem_rsp_valid_i) begin
            if (!last_word) begin
              mism_d   = mism_now;
              cur_word = 1'b1;
              state_d  = ST_READ;
            end else if (!verify_q && mism_now) begin
              // Frame is dirty: rewrite it from its first word.
              mism_d   = 1'b0;
              cur_wrap = 1'b1;
              state_d  = ST_FIX;
            end else begin
              fail_hit = verify_q && mism_now;
              verify_d = 1'b0;
              mism_d   = 1'b0;
              if (last_frame) begin
                state_d = ST_IDLE;
              end else begin
                cur_frame = 1'b1;
                state_d   = ST_READ;
              end
            end
          end
        end
        ST_FIX: begin
          if (hs) begin
            if (last_word) begin
              cur_wrap = 1'b1;
              verify_d = 1'b1;
              fix_done = 1'b1;
              state_d  = ST_READ;
            end else begin
              cur_word = 1'b1;
            end
          end
        end
        ST_FULL: begin
          if (hs) begin
            if (last_word && last_frame) begin
              state_d = ST_IDLE;
            end else if (last_word) begin
              cur_frame = 1'b1;
            end else begin
              cur_word = 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      verify_q <= 1'b0;
      mism_q   <= 1'b0;
      sefi_q   <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      fail_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      verify_q <= verify_d;
      mism_q   <= mism_d;
      sefi_q   <= sefi_i;
      pend_q   <= sefi_rise || (pend_q && !go_full);
      if (fix_done && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
      if (fail_hit) fail_q <= 1'b1;
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign user_en_o     = !(pend_q || (state_q == ST_FULL));
  assign repaired_o    = cnt_q;
  assign repair_fail_o = fail_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o))); // R7
  AST_SEFI_GATES_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sefi_i) |=> !user_en_o); // R6
  AST_FULL_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_FULL) && ($past(state_q) != ST_FULL)) |-> (mem_req_addr_o == '0)); // R6
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(repair_fail_o) |-> repair_fail_o); // R5
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repaired_o != $past(repaired_o)) |-> (repaired_o == $past(repaired_o) + 1'b1)); // R3
endmodule

// File: tb/test_scrub_ctrl.sv
`timescale 1ns/1ps
module test_scrub_ctrl;
  localparam int FR  = 3;
  localparam int WD  = 4;
  localparam int TOT = FR * WD;
  localparam int DW  = 16;
  localparam int PW  = 8;
  localparam int AW  = 4;
  localparam int CW  = 8;

  typedef struct packed {
    logic       bp;
    logic       en0;
    logic [3:0] a0;
    logic       en1;
    logic [3:0] a1;
    logic [1:0] delta;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  2'd0},
    '{1'b0, 1'b1, 4'd5,  1'b0, 4'd0,  2'd1},
    '{1'b1, 1'b1, 4'd0,  1'b1, 4'd3,  2'd1},
    '{1'b1, 1'b1, 4'd2,  1'b1, 4'd11, 2'd2},
    '{1'b0, 1'b1, 4'd8,  1'b1, 4'd9,  2'd1},
    '{1'b1, 1'b1, 4'd3,  1'b1, 4'd7,  2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] period = 8'd120;
  logic sefi = 1'b0;
  logic req_valid, req_ready, req_we, rsp_valid;
  logic [AW-1:0] req_addr, gold_addr;
  logic [DW-1:0] req_wdata, rsp_data, gold_data;
  logic busy, user_en, fail;
  logic [CW-1:0] repaired;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] gold_of(input int a);
    return DW'((a * 933) ^ 50010);
  endfunction

  assign gold_data = gold_of(int'(gold_addr));

  scrub_ctrl #(.FRAMES(FR), .WORDS(WD), .DATA_W(DW), .PERIOD_W(PW), .CNT_W(CW)) i_scrub_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scrub_period_i(period), .sefi_i(sefi),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_we_o(req_we),
    .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wdata),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .gold_addr_o(gold_addr), .gold_data_i(gold_data),
    .busy_o(busy), .user_en_o(user_en), .repaired_o(repaired), .repair_fail_o(fail)
  );

  // Store model, injection port and protocol monitors.
  logic [DW-1:0] mem [TOT];
  logic bp = 1'b0, stuck_en = 1'b0;
  logic inj_req = 1'b0, inj_en0 = 1'b0, inj_en1 = 1'b0;
  logic [3:0] inj_a0 = '0, inj_a1 = '0;
  int cyc = 0, rd_cnt = 0, wr_cnt = 0, full_wr = 0, full_err = 0, full_next = 0;
  int hold_err = 0, range_err = 0, ue_low = 0, rc = 0;
  logic prev_stall = 1'b0, prev_we = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  localparam int STUCK_A = 9;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < TOT; i++) mem[i] <= gold_of(i);
      rsp_valid <= 1'b0;
      req_ready <= 1'b1;
      rc <= 0;
      prev_stall <= 1'b0;
    end else begin
      rc <= (rc == 2) ? 0 : rc + 1;
      req_ready <= !bp || (rc != 2);
      rsp_valid <= 1'b0;
      if (inj_req) begin
        if (inj_en0) mem[inj_a0] <= mem[inj_a0] ^ 16'h0010;
        if (inj_en1) mem[inj_a1] <= mem[inj_a1] ^ 16'h8001;
      end
      if (req_valid && int'(req_addr) >= TOT) range_err <= range_err + 1;
      if (prev_stall && !(req_valid && req_addr == prev_addr && req_we == prev_we))
        hold_err <= hold_err + 1;
      prev_stall <= req_valid && !req_ready;
      prev_addr  <= req_addr;
      prev_we    <= req_we;
      if (!user_en) ue_low <= ue_low + 1;
      if (req_valid && req_ready && int'(req_addr) < TOT) begin
        if (req_we) begin
          if (!(stuck_en && int'(req_addr) == STUCK_A)) mem[req_addr] <= req_wdata;
          wr_cnt <= wr_cnt + 1;
          if (!user_en) begin
            full_wr <= full_wr + 1;
            if (int'(req_addr) != full_next) full_err <= full_err + 1;
            full_next <= (int'(req_addr) + 1) % TOT;
          end
        end else begin
          rsp_valid <= 1'b1;
          rsp_data  <= mem[req_addr];
          rd_cnt    <= rd_cnt + 1;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dirty_words();
    int n = 0;
    for (int i = 0; i < TOT; i++) if (mem[i] != gold_of(i)) n++;
    return n;
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!busy);
  endtask

  task automatic wait_pass();
    wait_rise();
    while (busy) @(negedge clk);
  endtask

  task automatic inject(input logic e0, input logic [3:0] a0, input logic e1, input logic [3:0] a1);
    inj_en0 = e0; inj_a0 = a0; inj_en1 = e1; inj_a1 = a1; inj_req = 1'b1;
    @(negedge clk);
    inj_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int t1, t2, t3, t4, rd0, wr0, c0, ue0, fw0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(busy == 1'b0, "R9 busy", busy, 0);
    chk(user_en == 1'b1, "R9 user_en", user_en, 1);
    chk(repaired == 0, "R9 repaired", int'(repaired), 0);
    chk(fail == 1'b0, "R9 fail", fail, 0);
    chk(req_valid == 1'b0, "R9 req_valid", req_valid, 0);

    // R1: pass spacing follows the programmed period
    wait_rise(); t1 = cyc;
    wait_idle(); wait_rise(); t2 = cyc;
    chk(t2 - t1 == 120, "R1 spacing 120", t2 - t1, 120);
    wait_idle();
    period = 8'd90;
    wait_rise(); t3 = cyc;
    wait_idle(); wait_rise(); t4 = cyc;
    chk(t3 - t2 == 90, "R1 spacing after change", t3 - t2, 90);
    chk(t4 - t3 == 90, "R1 spacing 90", t4 - t3, 90);
    wait_idle();

    ue0 = ue_low;
    // Table: R2 read totals, R3 repair totals and store contents
    for (int v = 0; v < NV; v++) begin
      bp = VEC[v].bp;
      wait_idle();
      rd0 = rd_cnt; wr0 = wr_cnt; c0 = int'(repaired);
      inject(VEC[v].en0, VEC[v].a0, VEC[v].en1, VEC[v].a1);
      wait_pass();
      @(negedge clk);
      chk(rd_cnt - rd0 == TOT + WD * int'(VEC[v].delta), "R2 reads in pass",
          rd_cnt - rd0, TOT + WD * int'(VEC[v].delta));
      chk(wr_cnt - wr0 == WD * int'(VEC[v].delta), "R3 writes in pass",
          wr_cnt - wr0, WD * int'(VEC[v].delta));
      chk(int'(repaired) - c0 == int'(VEC[v].delta), "R3 repaired step",
          int'(repaired) - c0, int'(VEC[v].delta));
      chk(dirty_words() == 0, "R3 store clean", dirty_words(), 0);
    end
    bp = 1'b0;

    // R5: dropped rewrite raises the sticky failure flag
    wait_idle();
    chk(fail == 1'b0, "R5 fail clear before", fail, 0);
    stuck_en = 1'b1;
    rd0 = rd_cnt; wr0 = wr_cnt; c0 = int'(repaired);
    inject(1'b1, 4'(STUCK_A), 1'b0, 4'd0);
    wait_pass();
    @(negedge clk);
    chk(fail == 1'b1, "R5 fail set", fail, 1);
    chk(int'(repaired) - c0 == 1, "R5 repair counted", int'(repaired) - c0, 1);
    chk(rd_cnt - rd0 == TOT + WD, "R5 confirm reads", rd_cnt - rd0, TOT + WD);
    stuck_en = 1'b0;
    c0 = int'(repaired);
    wait_pass();
    @(negedge clk);
    chk(int'(repaired) - c0 == 1, "R5 later repair", int'(repaired) - c0, 1);
    chk(fail == 1'b1, "R5 fail sticky", fail, 1);
    chk(dirty_words() == 0, "R5 store clean", dirty_words(), 0);
    chk(ue_low - ue0 == 0, "R4 user_en low cycles", ue_low - ue0, 0);

    // R6: interrupt aborts the pass and rewrites everything
    wait_idle();
    inject(1'b1, 4'd6, 1'b1, 4'd10);
    c0 = int'(repaired); fw0 = full_wr;
    wait_rise();
    repeat (2) @(negedge clk);
    sefi = 1'b1;
    @(negedge clk);
    chk(user_en == 1'b0, "R6 user_en low", user_en, 0);
    chk(busy == 1'b1, "R6 busy", busy, 1);
    repeat (3) @(negedge clk);
    sefi = 1'b0;
    while (!user_en) @(negedge clk);
    chk(full_wr - fw0 == TOT, "R6 full write count", full_wr - fw0, TOT);
    chk(full_err == 0, "R6 ascending from zero", full_err, 0);
    chk(int'(repaired) == c0, "R6 no repair counted", int'(repaired), c0);
    chk(dirty_words() == 0, "R6 store clean", dirty_words(), 0);
    chk(busy == 1'b0, "R6 busy released", busy, 0);

    chk(hold_err == 0, "R7 request hold", hold_err, 0);
    chk(range_err == 0, "R8 address range", range_err, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule